// File: doc/BRIEF.md
# Sixteen-bit arithmetic and logic unit with flag word

This block computes one arithmetic, logic or single-bit shift operation per cycle on two operands and returns the result without a clock. Alongside the result it derives six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. When the execute strobe is high, those flags are captured into a 16-bit flag word on the next rising clock edge. Each operation updates only its own subset of the flags, and the flags it does not touch keep their stored value.

The flag word also holds three control bits: trap, interrupt enable and direction. They are loaded through a separate write port, and that write leaves the condition flags alone. A size select chooses between word and byte operation. In byte mode the low eight bits carry the operation, bit 7 is the most significant bit for every flag, and the upper result byte is zero. A separate carry-in input feeds the add-with-carry and subtract-with-borrow operations.

Top module: `alu_flags_top`

## Requirements
- R1: Opcode 0 (add) gives a+b, and opcode 1 (add with carry) gives a+b+carry_in, both modulo the operand width. Carry (flag bit 0) is the carry out of the most significant bit.
- R2: Opcode 2 (subtract) gives a-b, and opcode 3 (subtract with borrow) gives a-b-carry_in. Carry (flag bit 0) is set when the unsigned subtraction needs a borrow.
- R3: For opcodes 0-3, 7 and 8, overflow (flag bit 11) is set exactly when the signed result falls outside the signed range of the operand width. This is the same as carry into the MSB differing from carry out of it.
- R4: For opcodes 0-3, 7 and 8, auxiliary carry (flag bit 4) is the carry or borrow across bit 3. Logic and shift operations clear it.
- R5: For every flag-updating operation, parity (flag bit 2) is 1 when bits 7..0 of the result hold an even number of ones.
- R6: For every flag-updating operation, zero (flag bit 6) is set when the result is zero, and sign (flag bit 7) copies the result MSB.
- R7: When byte_mode is 1, only operand bits 7..0 are used, the MSB is bit 7, and result bits 15..8 are zero.
- R8: Opcodes 4, 5 and 6 (AND, OR, XOR) clear carry, overflow and auxiliary carry.
- R9: Opcodes 7 (a+1) and 8 (a-1) update all condition flags except carry, which keeps its stored value.
- R10: Opcode 9 (one's complement of a) changes no flag. Opcodes 12-15 return a and change no flag.
- R11: Opcode 10 shifts a left by one and opcode 11 shifts it right by one, filling with zero. Carry takes the bit shifted out. Overflow is the new MSB XOR carry for the left shift, and the old MSB for the right shift.
- R12: Flag bits are carry 0, parity 2, aux 4, zero 6, sign 7, trap 8, interrupt 9, direction 10 and overflow 11. All other bits read 0, and the whole word is 0 after reset.
- R13: With ctl_we high, ctl_wdata bits 0, 1 and 2 load trap, interrupt and direction at the clock edge, and the condition flags are not changed by that write.
- R14: The flag word changes only at a rising clock edge where exec_en or ctl_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_sel | input | 4 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| carry_in | input | 1 | Carry or borrow in for opcodes 1 and 3 |
| exec_en | input | 1 | Capture the condition flags at the next edge |
| ctl_we | input | 1 | Load the control flags |
| ctl_wdata | input | 3 | Trap, interrupt and direction values (bits 0, 1, 2) |
| result | output | 16 | Combinational result |
| flags | output | 16 | Registered flag word |

## Verification
Random operand pairs in both sizes cover ordinary sums and differences, where the carry, overflow, auxiliary and parity rules seldom agree with each other. Directed values isolate each flag: 0x7FFF+1 raises overflow without carry, 0xFFFF+1 raises carry and zero without overflow, and 0x8000-1 raises a subtract overflow. The byte value 0x7F+1 shows that bit 7 acts as the MSB. Carry-in variations separate add from add-with-carry and subtract from subtract-with-borrow. Control writes, increments, complements and idle cycles are run against a nonzero stored flag word, so that a flag which should hold is told apart from one that is cleared.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_INC = 4'd7,
    OP_DEC = 4'd8, OP_NOT = 4'd9, OP_SHL = 4'd10, OP_SHR = 4'd11
  } alu_op_e;

  // flag word bit positions
  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_TF = 8;
  localparam int FB_IF = 9;
  localparam int FB_DF = 10;
  localparam int FB_OF = 11;
  localparam int COND_N = 6;
  localparam int CTL_N = 3;

  typedef struct packed {
    logic ov;
    logic sg;
    logic zr;
    logic ac;
    logic pr;
    logic cy;
  } cond_t;

  function automatic logic even_ones8(input logic [7:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        op_sel,
  input  logic              byte_mode,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output cond_t             cond_new,
  output cond_t             cond_wmask,
  output logic              carry_msb_in,
  output logic              carry_msb_out
);
  localparam int EXT_W = DATA_W + 1;
  localparam int HI_W  = DATA_W - 8;

  function automatic logic msb_of(input logic [DATA_W-1:0] v, input logic bsel);
    return bsel ? v[7] : v[DATA_W-1];
  endfunction

  function automatic logic [EXT_W-1:0] add_sub(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic c, input logic sub);
    if (sub) return {1'b0, x} - {1'b0, y} - EXT_W'(c);
    return {1'b0, x} + {1'b0, y} + EXT_W'(c);
  endfunction

  logic [DATA_W-1:0] lane_mask, am, bmk, opnd_b;
  logic [DATA_W-1:0] arith_res, xor_trace, shl_res;
  logic [EXT_W-1:0]  ext;
  logic              cin_sel, do_sub, nib_carry;

  always_comb begin
    lane_mask = {{HI_W{~byte_mode}}, 8'hFF};
    am        = op_a & lane_mask;
    bmk       = op_b & lane_mask;
    opnd_b    = bmk;
    cin_sel   = 1'b0;
    do_sub    = 1'b0;
    case (alu_op_e'(op_sel))
      OP_ADC: cin_sel = carry_in;
      OP_SUB: do_sub = 1'b1;
      OP_SBB: begin do_sub = 1'b1; cin_sel = carry_in; end
      OP_INC: opnd_b = DATA_W'(1);
      OP_DEC: begin opnd_b = DATA_W'(1); do_sub = 1'b1; end
      default: ;
    endcase
  end

  assign ext           = add_sub(am, opnd_b, cin_sel, do_sub);
  assign arith_res     = ext[DATA_W-1:0] & lane_mask;
  assign xor_trace     = am ^ opnd_b ^ ext[DATA_W-1:0];
  assign carry_msb_in  = msb_of(xor_trace, byte_mode);
  assign carry_msb_out = byte_mode ? ext[8] : ext[DATA_W];
  assign nib_carry     = xor_trace[4];
  assign shl_res       = (am << 1) & lane_mask;

  always_comb begin
    result     = am;
    cond_new   = '0;
    cond_wmask = '0;
    case (alu_op_e'(op_sel))
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        result      = arith_res;
        cond_new.cy = carry_msb_out;
        cond_new.ov = carry_msb_in ^ carry_msb_out;
        cond_new.ac = nib_carry;
        cond_wmask  = '1;
      end
      OP_INC, OP_DEC: begin
        result        = arith_res;
        cond_new.ov   = carry_msb_in ^ carry_msb_out;
        cond_new.ac   = nib_carry;
        cond_wmask    = '1;
        cond_wmask.cy = 1'b0;
      end
      OP_AND: begin result = am & bmk; cond_wmask = '1; end
      OP_OR:  begin result = am | bmk; cond_wmask = '1; end
      OP_XOR: begin result = am ^ bmk; cond_wmask = '1; end
      OP_NOT: result = ~am & lane_mask;
      OP_SHL: begin
        result      = shl_res;
        cond_new.cy = msb_of(am, byte_mode);
        cond_new.ov = msb_of(shl_res, byte_mode) ^ msb_of(am, byte_mode);
        cond_wmask  = '1;
      end
      OP_SHR: begin
        result      = am >> 1;
        cond_new.cy = am[0];
        cond_new.ov = msb_of(am, byte_mode);
        cond_wmask  = '1;
      end
      default: result = am;
    endcase
    cond_new.zr = (result == '0);
    cond_new.sg = msb_of(result, byte_mode);
    cond_new.pr = even_ones8(result[7:0]);
  end
endmodule

// File: rtl/alu_flagword.sv
module alu_flagword
  import alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  cond_t             cond_new,
  input  cond_t             cond_wmask,
  input  logic              ctl_we,
  input  logic [CTL_N-1:0]  ctl_wdata,
  output logic [WORD_W-1:0] flag_word
);
  logic [COND_N-1:0] cond_q, cond_d;
  logic [CTL_N-1:0]  ctl_q;
  cond_t             cq;

  for (genvar i = 0; i < COND_N; i++) begin : g_bit
    assign cond_d[i] = (exec_en && cond_wmask[i]) ? cond_new[i] : cond_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      ctl_q  <= '0;
    end else begin
      cond_q <= cond_d;
      if (ctl_we) ctl_q <= ctl_wdata;
    end
  end

  assign cq = cond_t'(cond_q);

  always_comb begin
    flag_word        = '0;
    flag_word[FB_CF] = cq.cy;
    flag_word[FB_PF] = cq.pr;
    flag_word[FB_AF] = cq.ac;
    flag_word[FB_ZF] = cq.zr;
    flag_word[FB_SF] = cq.sg;
    flag_word[FB_OF] = cq.ov;
    flag_word[FB_TF] = ctl_q[0];
    flag_word[FB_IF] = ctl_q[1];
    flag_word[FB_DF] = ctl_q[2];
  end
endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top
  import alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        op_sel,
  input  logic              byte_mode,
  input  logic              carry_in,
  input  logic              exec_en,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  output logic [DATA_W-1:0] result,
  output logic [15:0]       flags
);
  cond_t cond_new, cond_wmask;
  logic  carry_msb_in, carry_msb_out;

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .byte_mode(byte_mode),
    .carry_in(carry_in), .result(result), .cond_new(cond_new),
    .cond_wmask(cond_wmask), .carry_msb_in(carry_msb_in),
    .carry_msb_out(carry_msb_out)
  );

  alu_flagword #(.WORD_W(16)) u_fw (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .cond_new(cond_new),
    .cond_wmask(cond_wmask), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .flag_word(flags)
  );
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op_sel,
  input logic        byte_mode,
  input logic        exec_en,
  input logic        ctl_we,
  input logic [2:0]  ctl_wdata,
  input logic [15:0] result,
  input logic [15:0] flags,
  input logic        carry_msb_in,
  input logic        carry_msb_out
);
  logic is_arith, is_logic, is_incdec, updates_zf;
  assign is_arith   = (op_sel <= 4'd3);
  assign is_logic   = (op_sel >= 4'd4) && (op_sel <= 4'd6);
  assign is_incdec  = (op_sel == 4'd7) || (op_sel == 4'd8);
  assign updates_zf = (op_sel <= 4'd11) && (op_sel != 4'd9);

  assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & 16'hF02A) == 16'h0000);

  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> result[15:8] == 8'h00);

  assert_ov_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_arith |=> flags[11] == $past(carry_msb_in ^ carry_msb_out));

  assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_logic |=> !flags[0] && !flags[11] && !flags[4]);

  assert_incdec_keep_cf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && is_incdec |=> flags[0] == $past(flags[0]));

  assert_not_no_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == 4'd9 && !ctl_we |=> $stable(flags));

  assert_zf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && updates_zf |=> flags[6] == ($past(result) == 16'h0000));

  assert_ctl_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && !exec_en |=> (flags[7:0] == $past(flags[7:0])) &&
                           (flags[11] == $past(flags[11])) &&
                           (flags[10:8] == $past(ctl_wdata)));

  assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en && !ctl_we |=> $stable(flags));
endmodule

bind alu_flags_top alu_flags_chk u_chk (.*);

// File: tb/sim_alu_flags_top.sv
module sim_alu_flags_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  op_sel = '0;
  logic        byte_mode = 1'b0, carry_in = 1'b0, exec_en = 1'b0, ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = '0;
  logic [15:0] result, flags;

  int n_checks = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [15:0] exp_flags = '0;

  always #4 clk = ~clk;

  alu_flags_top u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .byte_mode(byte_mode), .carry_in(carry_in), .exec_en(exec_en),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .result(result), .flags(flags)
  );

  // reference model: returns {new_flags, result}
  function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [3:0] op, input logic bm,
                                        input logic ci, input logic [15:0] fin);
    int mask, half, ua, ub, sa, sb, r, full, sfull, opnd, c;
    logic cf, of, af, keep_cf, upd;
    logic [15:0] fo, rv;
    mask = bm ? 255 : 65535;
    half = (mask + 1) / 2;
    ua = int'(a) & mask;
    ub = int'(b) & mask;
    sa = (ua >= half) ? ua - (mask + 1) : ua;
    fo = fin; cf = 0; of = 0; af = 0; keep_cf = 0; upd = 1; r = ua;
    case (op)
      4'd0, 4'd1, 4'd7: begin
        opnd = (op == 4'd7) ? 1 : ub;
        c = (op == 4'd1) ? int'(ci) : 0;
        sb = (opnd >= half) ? opnd - (mask + 1) : opnd;
        full = ua + opnd + c;
        r = full & mask;
        cf = full > mask;
        af = ((ua & 15) + (opnd & 15) + c) > 15;
        sfull = sa + sb + c;
        of = (sfull >= half) || (sfull < -half);
        keep_cf = (op == 4'd7);
      end
      4'd2, 4'd3, 4'd8: begin
        opnd = (op == 4'd8) ? 1 : ub;
        c = (op == 4'd3) ? int'(ci) : 0;
        sb = (opnd >= half) ? opnd - (mask + 1) : opnd;
        full = ua - opnd - c;
        r = full & mask;
        cf = full < 0;
        af = (ua & 15) < ((opnd & 15) + c);
        sfull = sa - sb - c;
        of = (sfull >= half) || (sfull < -half);
        keep_cf = (op == 4'd8);
      end
      4'd4: r = ua & ub;
      4'd5: r = ua | ub;
      4'd6: r = ua ^ ub;
      4'd9: begin r = (~ua) & mask; upd = 0; end
      4'd10: begin
        r = (ua << 1) & mask;
        cf = (ua & half) != 0;
        of = ((r & half) != 0) ^ cf;
      end
      4'd11: begin
        r = ua >> 1;
        cf = ua[0];
        of = (ua & half) != 0;
      end
      default: upd = 0;
    endcase
    rv = r[15:0];
    if (upd) begin
      if (!keep_cf) fo[0] = cf;
      fo[11] = of;
      fo[4] = af;
      fo[6] = (rv == 16'h0000);
      fo[7] = bm ? rv[7] : rv[15];
      fo[2] = ~^rv[7:0];
    end
    return {fo, rv};
  endfunction

  function automatic string tag_of(input logic [3:0] op, input logic bm);
    string t;
    case (op)
      4'd0, 4'd1: t = "R1";
      4'd2, 4'd3: t = "R2";
      4'd4, 4'd5, 4'd6: t = "R8";
      4'd7, 4'd8: t = "R9";
      4'd10, 4'd11: t = "R11";
      default: t = "R10";
    endcase
    if (bm) t = {t, " R7"};
    return t;
  endfunction

  task automatic check16(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic [3:0] op,
                        input logic bm, input logic ci);
    logic [31:0] m;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; byte_mode = bm; carry_in = ci; exec_en = 1'b1;
    m = model(a, b, op, bm, ci, exp_flags);
    #1;
    check16(tag_of(op, bm), "result", result, m[15:0]);
    @(negedge clk);
    exec_en = 1'b0;
    exp_flags = m[31:16];
    #1;
    check16({tag_of(op, bm), " R3 R4 R5 R6"}, "flags", flags, exp_flags);
  endtask

  task automatic ctl_write(input logic [2:0] v, input logic with_exec, input logic [3:0] op);
    logic [31:0] m;
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v; exec_en = with_exec; op_sel = op;
    op_a = 16'h00F0; op_b = 16'h000F; byte_mode = 1'b0; carry_in = 1'b0;
    m = model(op_a, op_b, op, 1'b0, 1'b0, exp_flags);
    @(negedge clk);
    ctl_we = 1'b0; exec_en = 1'b0;
    if (with_exec) exp_flags = m[31:16];
    exp_flags[8] = v[0]; exp_flags[9] = v[1]; exp_flags[10] = v[2];
    #1;
    check16("R13", "flags after control write", flags, exp_flags);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check16("R12", "flags in reset", flags, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check16("R12", "flags after reset", flags, 16'h0000);

    // directed corners
    run_op(16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b0); // R3 overflow, no carry
    run_op(16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b0); // R1 carry and zero
    run_op(16'h1234, 16'h0FFF, 4'd1, 1'b0, 1'b1); // R1 carry_in used
    run_op(16'h8000, 16'h0001, 4'd2, 1'b0, 1'b0); // R3 subtract overflow
    run_op(16'h0000, 16'h0001, 4'd2, 1'b0, 1'b0); // R2 borrow
    run_op(16'h0005, 16'h0005, 4'd3, 1'b0, 1'b1); // R2 borrow in
    run_op(16'hAB7F, 16'hCD01, 4'd0, 1'b1, 1'b0); // R7 byte overflow at bit 7
    run_op(16'h00FF, 16'h0001, 4'd0, 1'b0, 1'b0); // R4 nibble carry, R5
    run_op(16'hFFFF, 16'h0001, 4'd0, 1'b0, 1'b0); // set CF before inc
    run_op(16'h7FFF, 16'h0000, 4'd7, 1'b0, 1'b0); // R9 inc keeps CF
    run_op(16'h0001, 16'h0000, 4'd8, 1'b0, 1'b0); // R9 dec to zero
    run_op(16'hF0F0, 16'h0FF0, 4'd4, 1'b0, 1'b0); // R8
    run_op(16'h1234, 16'h0000, 4'd9, 1'b0, 1'b0); // R10 no flag change
    run_op(16'h8001, 16'h0000, 4'd10, 1'b0, 1'b0); // R11 shl out
    run_op(16'h4000, 16'h0000, 4'd10, 1'b0, 1'b0); // R11 shl overflow
    run_op(16'h0081, 16'h0000, 4'd11, 1'b1, 1'b0); // R11 byte shr
    run_op(16'hBEEF, 16'h1111, 4'd13, 1'b0, 1'b0); // R10 reserved op

    // control flags: R13
    ctl_write(3'b101, 1'b0, 4'd0);
    ctl_write(3'b010, 1'b1, 4'd6);
    ctl_write(3'b111, 1'b0, 4'd0);

    // idle hold: R14
    repeat (4) begin
      @(negedge clk);
      op_a = 16'($urandom()); op_b = 16'($urandom()); op_sel = 4'd0;
    end
    #1;
    check16("R14", "flags held while idle", flags, exp_flags);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(12, 15))
                                        : 4'($urandom_range(0, 11));
      run_op(16'($urandom()), 16'($urandom()), op, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)));
    end

    // reset returns flag word to zero: R12
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_flags = '0;
    check16("R12", "flags after second reset", flags, 16'h0000);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule